// File: doc/BRIEF.md
# Byte Arithmetic-Logic Unit with Status Flags

This block is a purely combinational arithmetic-logic unit for byte-wide operands. Two operands, `a_i` and `b_i`, feed eight operation units at once: an adder, a right shifter, a left shifter, an inverter, three bitwise units and a magnitude comparator. A 3-bit selector then routes exactly one of those answers to the result byte and to the status flags. The other seven answers are discarded.

The block sits between operand sources and a result sink in a larger datapath. It holds no state, so its outputs follow its inputs within the same cycle. Two operations behave differently from the rest. The comparator produces no byte: it raises one of three relation flags and drives the result to zero. Both shifts report the bit that is pushed out of the operand on a dedicated flag. The operand width is a parameter with a default of 8. Parameters also choose between a rippled and a behavioural implementation of the adder and of the comparator.

Top module: `octet_alu`

## Requirements
- R1: With selector 000 (add), `res_o` is (A + B) modulo 256, and `carry_o` is 1 exactly when A + B exceeds 255 (for example, 0xFF + 0x01 gives 0x00 with carry 1).
- R2: With selector 001 (shift right), `res_o` is A moved one place toward bit 0, with bit 7 filled with 0. `shout_o` carries the old bit 0 of A, and B has no effect.
- R3: With selector 010 (shift left), `res_o` is A moved one place toward bit 7, with bit 0 filled with 0. `shout_o` carries the old bit 7 of A, and B has no effect.
- R4: With selector 011 (invert), `res_o` is A with every bit flipped, and B has no effect.
- R5: With selectors 100, 101 and 110, `res_o` is the bitwise AND, OR and XOR of A and B respectively. Each result bit depends only on the operand bits in the same position.
- R6: With selector 111 (compare), A and B are treated as unsigned. Exactly one of `eq_o`, `gt_o` and `lt_o` is 1, giving the relation of A to B, and `res_o` is 0x00.
- R7: `carry_o` is 0 unless the selector is 000. `shout_o` is 0 unless the selector is 001 or 010. `eq_o`, `gt_o` and `lt_o` are all 0 unless the selector is 111.
- R8: `zero_o` is 1 exactly when the selector is not 111 and `res_o` equals 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | First operand; the only operand for shifts and invert |
| b_i | input | 8 | Second operand |
| op_i | input | 3 | Operation selector |
| res_o | output | 8 | Selected result byte |
| carry_o | output | 1 | Carry out of the add |
| shout_o | output | 1 | Bit pushed out by a shift |
| eq_o | output | 1 | Compare: A equals B |
| gt_o | output | 1 | Compare: A greater than B |
| lt_o | output | 1 | Compare: A less than B |
| zero_o | output | 1 | Result byte is zero (not raised for compare) |

## Verification
The block holds no state, so a faulty unit appears at the ports in the same cycle as the operands that expose it. A broken link in the carry ripple appears only when a carry has to cross that bit, for example with 0xFF + 0x01. A broken link in the comparator chain appears only for operands that first differ at that bit. A wrong route in the selector, or a flag that is not blocked for other operations, shows up as soon as that selector value is applied. The bench therefore sweeps every value of A for every operation, pairs it with corner values of B, with B equal to A and with a random B, and compares every output against values computed with plain arithmetic.

// File: rtl/octet_alu_pkg.sv
package octet_alu_pkg;

   localparam int unsigned OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD = 3'b000,
      OP_SHR = 3'b001,
      OP_SHL = 3'b010,
      OP_NOT = 3'b011,
      OP_AND = 3'b100,
      OP_OR  = 3'b101,
      OP_XOR = 3'b110,
      OP_CMP = 3'b111
   } alu_op_e;

   // Mode encoding for the per-bit logic unit
   typedef enum logic [1:0] {
      LM_AND = 2'b00,
      LM_OR  = 2'b01,
      LM_XOR = 2'b10,
      LM_INV = 2'b11
   } logic_mode_e;

endpackage

// File: rtl/octet_alu_adder.sv
module octet_alu_adder #(
   parameter int unsigned WIDTH  = 8,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o
);

   if (WIDTH < 1) begin : g_bad_width
      $error("octet_alu_adder: WIDTH must be at least 1");
   end

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = 1'b0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic half;
         assign half         = a_i[i] ^ b_i[i];
         assign sum_o[i]     = half ^ chain[i];
         assign chain[i+1]   = (a_i[i] & b_i[i]) | (chain[i] & half);
      end
      assign cout_o = chain[WIDTH];
   end else begin : g_behav
      assign {cout_o, sum_o} = {1'b0, a_i} + {1'b0, b_i};
   end

   // The rippled sum must match plain arithmetic
   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         p_add_sum_r1: assert ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i}))
            else $error("adder sum/carry mismatch");
      end
   end

endmodule

// File: rtl/octet_alu_shifter.sv
module octet_alu_shifter #(
   parameter int unsigned WIDTH = 8,
   parameter bit          LEFT  = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   output logic [WIDTH-1:0] res_o,
   output logic             out_bit_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("octet_alu_shifter: WIDTH must be at least 2");
   end

   if (LEFT) begin : g_left
      assign res_o     = {a_i[WIDTH-2:0], 1'b0};
      assign out_bit_o = a_i[WIDTH-1];
      always_comb begin
         if (!$isunknown(a_i)) begin
            p_shl_fill_r3: assert (res_o[0] == 1'b0 && res_o[WIDTH-1] == a_i[WIDTH-2])
               else $error("left shift fill or move wrong");
         end
      end
   end else begin : g_right
      assign res_o     = {1'b0, a_i[WIDTH-1:1]};
      assign out_bit_o = a_i[0];
      always_comb begin
         if (!$isunknown(a_i)) begin
            p_shr_fill_r2: assert (res_o[WIDTH-1] == 1'b0 && res_o[0] == a_i[1])
               else $error("right shift fill or move wrong");
         end
      end
   end

endmodule

// File: rtl/octet_alu_logic.sv
module octet_alu_logic
   import octet_alu_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic_mode_e      mode_i,
   output logic [WIDTH-1:0] res_o
);

   // Each column is computed by its own cell, with no path between columns
   for (genvar i = 0; i < WIDTH; i++) begin : g_col
      always_comb begin
         unique case (mode_i)
            LM_AND:  res_o[i] = a_i[i] & b_i[i];
            LM_OR:   res_o[i] = a_i[i] | b_i[i];
            LM_XOR:  res_o[i] = a_i[i] ^ b_i[i];
            LM_INV:  res_o[i] = ~a_i[i];
            default: res_o[i] = 1'b0;
         endcase
      end
   end

   always_comb begin
      if (!$isunknown({a_i, mode_i})) begin
         p_inv_ignores_b_r4: assert (mode_i != LM_INV || (res_o ^ a_i) == {WIDTH{1'b1}})
            else $error("invert result depends on more than A");
      end
   end

endmodule

// File: rtl/octet_alu_compare.sv
module octet_alu_compare #(
   parameter int unsigned WIDTH  = 8,
   parameter bit          RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic             eq_o,
   output logic             gt_o,
   output logic             lt_o
);

   if (RIPPLE) begin : g_ripple
      // Walk from the top bit down; the first differing bit decides
      logic [WIDTH:0] gt_c;
      logic [WIDTH:0] lt_c;
      assign gt_c[WIDTH] = 1'b0;
      assign lt_c[WIDTH] = 1'b0;
      for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_bit
         logic open;
         assign open    = ~(gt_c[i+1] | lt_c[i+1]);
         assign gt_c[i] = gt_c[i+1] | (open & a_i[i] & ~b_i[i]);
         assign lt_c[i] = lt_c[i+1] | (open & ~a_i[i] & b_i[i]);
      end
      assign gt_o = gt_c[0];
      assign lt_o = lt_c[0];
      assign eq_o = ~(gt_c[0] | lt_c[0]);
   end else begin : g_behav
      assign gt_o = a_i > b_i;
      assign lt_o = a_i < b_i;
      assign eq_o = a_i == b_i;
   end

   always_comb begin
      if (!$isunknown({a_i, b_i})) begin
         p_cmp_onehot_r6: assert ($onehot({eq_o, gt_o, lt_o}))
            else $error("compare flags not one-hot");
         p_cmp_eq_r6: assert (eq_o == (a_i == b_i))
            else $error("equal flag wrong");
      end
   end

endmodule

// File: rtl/octet_alu.sv
module octet_alu
   import octet_alu_pkg::*;
#(
   parameter int unsigned WIDTH      = 8,
   parameter bit          ADD_RIPPLE = 1'b1,
   parameter bit          CMP_RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [2:0]       op_i,
   output logic [WIDTH-1:0] res_o,
   output logic             carry_o,
   output logic             shout_o,
   output logic             eq_o,
   output logic             gt_o,
   output logic             lt_o,
   output logic             zero_o
);

   localparam logic [WIDTH-1:0] ZERO_W = '0;

   if (WIDTH < 2) begin : g_bad_width
      $error("octet_alu: WIDTH must be at least 2");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_i);

   logic [WIDTH-1:0] sum, shr_res, shl_res, log_res;
   logic             cout, shr_bit, shl_bit, c_eq, c_gt, c_lt;
   logic_mode_e      lmode;

   assign lmode = (op == OP_NOT) ? LM_INV : logic_mode_e'(op_i[1:0]);

   octet_alu_adder #(.WIDTH(WIDTH), .RIPPLE(ADD_RIPPLE)) add_i (
      .a_i(a_i), .b_i(b_i), .sum_o(sum), .cout_o(cout)
   );

   octet_alu_shifter #(.WIDTH(WIDTH), .LEFT(1'b0)) shr_i (
      .a_i(a_i), .res_o(shr_res), .out_bit_o(shr_bit)
   );

   octet_alu_shifter #(.WIDTH(WIDTH), .LEFT(1'b1)) shl_i (
      .a_i(a_i), .res_o(shl_res), .out_bit_o(shl_bit)
   );

   octet_alu_logic #(.WIDTH(WIDTH)) log_i (
      .a_i(a_i), .b_i(b_i), .mode_i(lmode), .res_o(log_res)
   );

   octet_alu_compare #(.WIDTH(WIDTH), .RIPPLE(CMP_RIPPLE)) cmp_i (
      .a_i(a_i), .b_i(b_i), .eq_o(c_eq), .gt_o(c_gt), .lt_o(c_lt)
   );

   // Route exactly one unit to the outputs; every other flag stays low
   always_comb begin
      res_o   = ZERO_W;
      carry_o = 1'b0;
      shout_o = 1'b0;
      eq_o    = 1'b0;
      gt_o    = 1'b0;
      lt_o    = 1'b0;
      unique case (op)
         OP_ADD: begin
            res_o   = sum;
            carry_o = cout;
         end
         OP_SHR: begin
            res_o   = shr_res;
            shout_o = shr_bit;
         end
         OP_SHL: begin
            res_o   = shl_res;
            shout_o = shl_bit;
         end
         OP_NOT, OP_AND, OP_OR, OP_XOR: res_o = log_res;
         OP_CMP: begin
            eq_o = c_eq;
            gt_o = c_gt;
            lt_o = c_lt;
         end
         default: res_o = ZERO_W;
      endcase
   end

   assign zero_o = (op != OP_CMP) && (res_o == ZERO_W);

   always_comb begin
      if (!$isunknown({a_i, b_i, op_i})) begin
         p_carry_gate_r7: assert (op == OP_ADD || !carry_o)
            else $error("carry raised outside add");
         p_shout_gate_r7: assert (op == OP_SHR || op == OP_SHL || !shout_o)
            else $error("shift flag raised outside shifts");
         p_cmp_gate_r7: assert (op == OP_CMP || !(eq_o | gt_o | lt_o))
            else $error("compare flags raised outside compare");
         p_cmp_res_r6: assert (op != OP_CMP || res_o == ZERO_W)
            else $error("compare drove a nonzero byte");
         p_zero_cmp_r8: assert (op != OP_CMP || !zero_o)
            else $error("zero flag raised for compare");
         p_bitwise_r5: assert (op != OP_XOR || res_o == (a_i ^ b_i))
            else $error("xor route wrong");
      end
   end

endmodule

// File: tb/octet_alu_tb_top.sv
module octet_alu_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] a = '0, b = '0;
   logic [2:0] op = '0;
   logic [7:0] res;
   logic       carry, shout, eq, gt, lt, zero;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   octet_alu dut_i (
      .a_i(a), .b_i(b), .op_i(op),
      .res_o(res), .carry_o(carry), .shout_o(shout),
      .eq_o(eq), .gt_o(gt), .lt_o(lt), .zero_o(zero)
   );

   function automatic string op_tag(input logic [2:0] o);
      case (o)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R3";
         3'd3: return "R4";
         3'd7: return "R6";
         default: return "R5";
      endcase
   endfunction

   // Expected outputs packed as {res, carry, shout, eq, gt, lt, zero}
   function automatic logic [13:0] model(input logic [2:0] o, input logic [7:0] x,
                                         input logic [7:0] y);
      int unsigned s;
      logic [7:0] r = 8'h00;
      logic c = 0, so = 0, e = 0, g = 0, l = 0, z;
      case (o)
         3'd0: begin
            s = int'(x) + int'(y);
            r = 8'(s % 256);
            c = s > 255;
         end
         3'd1: begin r = 8'(x / 2); so = x[0]; end
         3'd2: begin r = 8'((int'(x) * 2) % 256); so = x >= 8'd128; end
         3'd3: r = 8'(255 - int'(x));
         3'd4: r = x & y;
         3'd5: r = x | y;
         3'd6: r = x ^ y;
         default: begin
            e = int'(x) == int'(y);
            g = int'(x) > int'(y);
            l = int'(x) < int'(y);
         end
      endcase
      z = (o != 3'd7) && (r == 8'h00);
      return {r, c, so, e, g, l, z};
   endfunction

   task automatic apply(input logic [2:0] o, input logic [7:0] x, input logic [7:0] y);
      logic [13:0] exp_v, got;
      string tag;
      @(negedge clk);
      op = o; a = x; b = y;
      #2;
      exp_v = model(o, x, y);
      got   = {res, carry, shout, eq, gt, lt, zero};
      checks++;
      if (got !== exp_v) begin
         errors++;
         if (got[13:6] !== exp_v[13:6] || got[4:2] !== exp_v[4:2]) tag = op_tag(o);
         else if (got[0] !== exp_v[0]) tag = "R8";
         else tag = "R7";
         $display("FAIL %s op=%0d a=%h b=%h got %h expected %h", tag, o, x, y, got, exp_v);
      end
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired got running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] bsel;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // R8: idle state after reset, add of zeros gives zero result and zero flag
      apply(3'd0, 8'h00, 8'h00);
      // R1: carry ripples across every bit
      apply(3'd0, 8'hFF, 8'h01);
      // R6: equal, greater and less at the top bit
      apply(3'd7, 8'h80, 8'h80);
      apply(3'd7, 8'h80, 8'h7F);
      apply(3'd7, 8'h7F, 8'h80);
      // R2, R3: the pushed-out bit
      apply(3'd1, 8'h01, 8'hFF);
      apply(3'd2, 8'h80, 8'h00);
      // R1..R8 sweep: every A, for every operation, against corner, equal and random B
      for (int o = 0; o < 8; o++) begin
         for (int x = 0; x < 256; x++) begin
            for (int k = 0; k < 6; k++) begin
               case (k)
                  0: bsel = 8'h00;
                  1: bsel = 8'hFF;
                  2: bsel = 8'h80;
                  3: bsel = 8'h01;
                  4: bsel = 8'(x);
                  default: bsel = 8'($urandom);
               endcase
               apply(3'(o), 8'(x), bsel);
            end
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule